// File: doc/BRIEF.md
# Interrupt Distributor

This block collects interrupt lines from up to a few dozen devices, holds their pending state, and presents to each of a small number of processors the single most urgent interrupt that is enabled and routed to that processor. Software sets it up through a word-wide register bus. Through the bus it sets each source's enable, priority, trigger mode and set of target processors. It can also raise software interrupts aimed at chosen processors.

Sources 0 to 15 are software interrupts and have no input line. Sources 16 to 31 are private to each processor: every processor has its own enable and pending copy, and the register bus shows the copy of the processor named on `bus_cpu_i`. Sources 16 to 31 take their line from the same shared input, which every private copy samples. Sources from 32 upward are shared and reach a processor only when that processor's bit is set in the source's target field. Hardware line `irq_i[k]` belongs to source k+16. Reads are combinational on `addr_i`. A write takes effect at the clock edge where `req_i` and `we_i` are high. The per-processor outputs are registered: they show the state one clock after that state changes.

Top module: `intr_dist`

## Requirements
- R1: The enable-set words at 0x100+4w and the enable-clear words at 0x180+4w cover sources 32w to 32w+31, with bit b mapping to source 32w+b. Writing 1 to a bit of a set word enables that source, writing 1 to a bit of a clear word disables it, and 0 bits change nothing. Reading either word returns the current enables.
- R2: Trigger words at 0xC00+4w hold two bits per source, 16 sources per word. Bit 2k+1 of word w selects rising-edge mode for source 16w+k, and 0 selects level mode. Bit 2k reads as 0. A level source is pending while its line is high. An edge source latches pending on a rising edge of its line and stays pending until a 1 is written to its bit in the pending-clear word at 0x280+4w. The pending words at 0x200+4w read back the pending state.
- R3: Writes to trigger word 0 (sources 0 to 15) are ignored, and that word always reads 0xAAAAAAAA.
- R4: Word 0 of the enable and pending registers (sources 0 to 31) is held separately for each processor. A bus access acts on the copy of the processor given by `bus_cpu_i`.
- R5: Priority words at 0x400+4w hold four 8-bit fields. Source 4w is in bits 7:0 and source 4w+3 is in bits 31:24. All priorities reset to 0.
- R6: Target words at 0x800+4w hold four 8-bit fields in the same order as the priority words. In each field, bit n routes the source to processor n. Shared targets reset to 0x01, and target words of sources below 32 read as 0.
- R7: Bit 0 of the control word at 0x000 gates forwarding. While it is 0, every `best_valid_o` bit is 0.
- R8: The read-only word at 0x004 returns NUM_SRC/32-1 in bits 4:0.
- R9: A write to 0x008 raises software interrupt `wdata[3:0]` as pending in the private copy of every processor n for which `wdata[16+n]` is 1.
- R10: For each processor, the output is the enabled, pending, routed source with the lowest priority value. Among equal priority values, the lowest source number wins.
- R11: After reset, all enables and pending latches are 0, forwarding is off, and every `best_valid_o` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC-16 | Device lines; bit k belongs to source k+16 |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1 |
| bus_cpu_i | input | CPU_W | Processor making the access; selects the private bank |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on the address |
| best_valid_o | output | NUM_CPU | Processor n has a candidate |
| best_id_o | output | NUM_CPU*ID_W | Candidate source number, ID_W bits per processor |
| best_prio_o | output | NUM_CPU*8 | Candidate priority, 8 bits per processor |

## Verification
The selection logic is driven with the following patterns:
- A single level source while forwarding is off, then on. This separates the global gate from the enable path.
- The same source routed to one processor, then the other, then both. This shows the target bits act per processor.
- Two level sources at equal priority, then with the higher-numbered one made more urgent. This separates the tie-break on source number from the priority compare.
- An edge source pulsed once and then held high across a pending clear. This shows that an edge latch stays set after its pulse and does not set again from a steady level.
- Software interrupts aimed at one processor at a time. These show the mask bits and the private banks.

// File: rtl/intr_dist_pkg.sv
package intr_dist_pkg;
  localparam int ADDR_W = 12;
  localparam int PRIO_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 12'h000;
  localparam logic [ADDR_W-1:0] A_TYPE = 12'h004;
  localparam logic [ADDR_W-1:0] A_SWI  = 12'h008;

  // addr[11:7] regions below 0x400
  localparam logic [4:0] R_EN_SET  = 5'h02;
  localparam logic [4:0] R_EN_CLR  = 5'h03;
  localparam logic [4:0] R_PND     = 5'h04;
  localparam logic [4:0] R_PND_CLR = 5'h05;

  // addr[11:10] regions
  localparam logic [1:0] G_PRIO = 2'b01;
  localparam logic [1:0] G_TGT  = 2'b10;
  localparam logic [1:0] G_CFG  = 2'b11;
endpackage

// File: rtl/intr_dist_edge.sv
module intr_dist_edge #(
  parameter int N = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/intr_dist_arb.sv
module intr_dist_arb
  import intr_dist_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        cand_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [ID_W-1:0]           id_o,
  output logic [PRIO_W-1:0]         prio_o
);
  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare keeps the lowest id on ties
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    best_p  = '1;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cand_i[s] && (!valid_o || prio_i[s*PRIO_W +: PRIO_W] < best_p)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(s);
        best_p  = prio_i[s*PRIO_W +: PRIO_W];
      end
    end
    prio_o = valid_o ? best_p : '0;
  end

  p_pick_is_cand_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cand_i[id_o]);
  p_pick_not_worse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cand_i[0]) |-> (prio_o <= prio_i[PRIO_W-1:0]));
endmodule

// File: rtl/intr_dist.sv
module intr_dist
  import intr_dist_pkg::*;
#(
  parameter  int NUM_SRC = 64,
  parameter  int NUM_CPU = 2,
  localparam int ID_W    = $clog2(NUM_SRC),
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int NUM_HW  = NUM_SRC - 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_HW-1:0]         irq_i,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [CPU_W-1:0]          bus_cpu_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic [NUM_CPU-1:0]        best_valid_o,
  output logic [NUM_CPU*ID_W-1:0]   best_id_o,
  output logic [NUM_CPU*PRIO_W-1:0] best_prio_o
);
  localparam int NUM_SH    = NUM_SRC - 32;
  localparam int EN_WORDS  = NUM_SRC / 32;
  localparam int PRI_WORDS = NUM_SRC / 4;
  localparam int CFG_WORDS = NUM_SRC / 16;

  logic                             ctrl_en;
  logic [NUM_CPU-1:0][31:0]         en_priv, lat_priv;
  logic [NUM_SH-1:0]                en_sh, lat_sh;
  logic [NUM_SRC*PRIO_W-1:0]        prio_q;
  logic [NUM_SH*NUM_CPU-1:0]        tgt_q;
  logic [NUM_HW-1:0]                edge_q;
  logic [NUM_HW-1:0]                rise;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]  pnd_view, cand;

  logic       wr;
  logic [4:0] lo_rgn;
  logic [1:0] hi_rgn;
  int         lo_idx, widx;

  assign wr     = req_i & we_i;
  assign lo_rgn = addr_i[11:7];
  assign hi_rgn = addr_i[11:10];
  assign lo_idx = int'(addr_i[6:2]);
  assign widx   = int'(addr_i[9:2]);

  intr_dist_edge #(.N(NUM_HW)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(irq_i), .rise_o(rise)
  );

  // per-processor pending and candidate views
  for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
    for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_src
      if (gs < 16) begin : g_sgi
        assign pnd_view[gc][gs] = lat_priv[gc][gs];
        assign cand[gc][gs]     = ctrl_en & en_priv[gc][gs] & lat_priv[gc][gs];
      end else if (gs < 32) begin : g_priv
        assign pnd_view[gc][gs] = edge_q[gs-16] ? lat_priv[gc][gs] : irq_i[gs-16];
        assign cand[gc][gs]     = ctrl_en & en_priv[gc][gs] & pnd_view[gc][gs];
      end else begin : g_sh
        assign pnd_view[gc][gs] = edge_q[gs-16] ? lat_sh[gs-32] : irq_i[gs-16];
        assign cand[gc][gs]     = ctrl_en & en_sh[gs-32] & pnd_view[gc][gs]
                                & tgt_q[(gs-32)*NUM_CPU + gc];
      end
    end

    logic              a_valid;
    logic [ID_W-1:0]   a_id;
    logic [PRIO_W-1:0] a_prio;

    intr_dist_arb #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
      .clk_i (clk_i), .rst_ni(rst_ni), .cand_i(cand[gc]), .prio_i(prio_q),
      .valid_o(a_valid), .id_o(a_id), .prio_o(a_prio)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        best_valid_o[gc]              <= 1'b0;
        best_id_o[gc*ID_W +: ID_W]    <= '0;
        best_prio_o[gc*PRIO_W +: PRIO_W] <= '0;
      end else begin
        best_valid_o[gc]              <= a_valid;
        best_id_o[gc*ID_W +: ID_W]    <= a_id;
        best_prio_o[gc*PRIO_W +: PRIO_W] <= a_prio;
      end
    end

    p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      best_valid_o[gc] |-> $past(ctrl_en));
    p_swi_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && addr_i == A_SWI && wdata_i[16+gc]) |=> lat_priv[gc][$past(wdata_i[3:0])]);
  end

  // register writes and pending latches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en  <= 1'b0;
      en_priv  <= '0;
      lat_priv <= '0;
      en_sh    <= '0;
      lat_sh   <= '0;
      prio_q   <= '0;
      edge_q   <= '0;
      for (int i = 0; i < NUM_SH; i++) tgt_q[i*NUM_CPU +: NUM_CPU] <= NUM_CPU'(1);
    end else begin
      for (int c = 0; c < NUM_CPU; c++)
        for (int s = 16; s < 32; s++)
          if (edge_q[s-16] && rise[s-16]) lat_priv[c][s] <= 1'b1;
      for (int s = 32; s < NUM_SRC; s++)
        if (edge_q[s-16] && rise[s-16]) lat_sh[s-32] <= 1'b1;

      if (wr) begin
        if (addr_i == A_CTRL) ctrl_en <= wdata_i[0];
        if (addr_i == A_SWI)
          for (int c = 0; c < NUM_CPU; c++)
            if (wdata_i[16+c]) lat_priv[c][wdata_i[3:0]] <= 1'b1;
        if (lo_rgn == R_EN_SET) begin
          if (lo_idx == 0) en_priv[bus_cpu_i] <= en_priv[bus_cpu_i] | wdata_i;
          else if (lo_idx < EN_WORDS)
            en_sh[(lo_idx-1)*32 +: 32] <= en_sh[(lo_idx-1)*32 +: 32] | wdata_i;
        end
        if (lo_rgn == R_EN_CLR) begin
          if (lo_idx == 0) en_priv[bus_cpu_i] <= en_priv[bus_cpu_i] & ~wdata_i;
          else if (lo_idx < EN_WORDS)
            en_sh[(lo_idx-1)*32 +: 32] <= en_sh[(lo_idx-1)*32 +: 32] & ~wdata_i;
        end
        // clear wins over a same-cycle edge
        if (lo_rgn == R_PND_CLR) begin
          if (lo_idx == 0) lat_priv[bus_cpu_i] <= lat_priv[bus_cpu_i] & ~wdata_i;
          else if (lo_idx < EN_WORDS)
            lat_sh[(lo_idx-1)*32 +: 32] <= lat_sh[(lo_idx-1)*32 +: 32] & ~wdata_i;
        end
        if (hi_rgn == G_PRIO && widx < PRI_WORDS) prio_q[widx*32 +: 32] <= wdata_i;
        if (hi_rgn == G_TGT && widx >= 8 && widx < PRI_WORDS)
          for (int k = 0; k < 4; k++)
            tgt_q[(widx*4+k-32)*NUM_CPU +: NUM_CPU] <= wdata_i[k*8 +: NUM_CPU];
        if (hi_rgn == G_CFG && widx >= 1 && widx < CFG_WORDS)
          for (int k = 0; k < 16; k++) edge_q[widx*16+k-16] <= wdata_i[2*k+1];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) rdata_o[0] = ctrl_en;
    if (addr_i == A_TYPE) rdata_o[4:0] = 5'(EN_WORDS - 1);
    if (lo_rgn == R_EN_SET || lo_rgn == R_EN_CLR) begin
      if (lo_idx == 0) rdata_o = en_priv[bus_cpu_i];
      else if (lo_idx < EN_WORDS) rdata_o = en_sh[(lo_idx-1)*32 +: 32];
    end
    if (lo_rgn == R_PND || lo_rgn == R_PND_CLR) begin
      if (lo_idx < EN_WORDS) rdata_o = pnd_view[bus_cpu_i][lo_idx*32 +: 32];
    end
    if (hi_rgn == G_PRIO && widx < PRI_WORDS) rdata_o = prio_q[widx*32 +: 32];
    if (hi_rgn == G_TGT && widx >= 8 && widx < PRI_WORDS)
      for (int k = 0; k < 4; k++)
        rdata_o[k*8 +: NUM_CPU] = tgt_q[(widx*4+k-32)*NUM_CPU +: NUM_CPU];
    if (hi_rgn == G_CFG) begin
      if (widx == 0) rdata_o = 32'hAAAA_AAAA;
      else if (widx < CFG_WORDS)
        for (int k = 0; k < 16; k++) rdata_o[2*k+1] = edge_q[widx*16+k-16];
    end
  end

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && hi_rgn == G_CFG) |=> $stable(edge_q));
  p_en_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && lo_rgn == R_EN_CLR && lo_idx == 1 && wdata_i[0]) |=> !en_sh[0]);
  p_en_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && lo_rgn == R_EN_SET && lo_idx == 0 && bus_cpu_i == '0) |=> $stable(en_priv[NUM_CPU-1]) || NUM_CPU == 1);
endmodule

// File: tb/intr_dist_tb_top.sv
`timescale 1ns/1ps
module intr_dist_tb_top;
  localparam int NUM_SRC = 64;
  localparam int NUM_CPU = 2;
  localparam int ID_W    = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] irq = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [0:0]  bcpu = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  bvalid;
  logic [11:0] bid;
  logic [15:0] bprio;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  intr_dist #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .bus_cpu_i(bcpu), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .best_valid_o(bvalid), .best_id_o(bid), .best_prio_o(bprio)
  );

  typedef struct {
    int    cpu;
    bit    valid;
    int    id;
    int    prio;
    string tag;
  } exp_t;
  exp_t sb_q[$];
  bit   sb_done = 1'b0;

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; bcpu = 1'(cpu); addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bcpu = 1'(cpu); addr = a;
    #1;
    n_run++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: read 0x%03h got 0x%08h expected 0x%08h", tag, a, rdata, exp);
    end
  endtask

  task automatic expect_out(input int cpu, input bit v, input int id, input int p, input string tag);
    exp_t e;
    e.cpu = cpu; e.valid = v; e.id = id; e.prio = p; e.tag = tag;
    sb_q.push_back(e);
    #1;
  endtask

  // monitor: compares queued expectations against the outputs
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      begin
        exp_t e;
        bit ok;
        int aid, ap;
        e = sb_q.pop_front();
        aid = int'(bid[e.cpu*ID_W +: ID_W]);
        ap  = int'(bprio[e.cpu*8 +: 8]);
        ok  = (bvalid[e.cpu] == e.valid) && (!e.valid || (aid == e.id && ap == e.prio));
        n_run++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s: cpu%0d got v=%0d id=%0d p=0x%02h expected v=%0d id=%0d p=0x%02h",
                   e.tag, e.cpu, bvalid[e.cpu], aid, ap, e.valid, e.id, e.prio);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    expect_out(0, 0, 0, 0, "R11 cpu0 idle");
    expect_out(1, 0, 0, 0, "R11 cpu1 idle");
    rd(0, 12'h100, 32'h0, "R11 enables zero");
    rd(0, 12'h000, 32'h0, "R11 forwarding off");
    rd(0, 12'h400, 32'h0, "R5 prio reset");
    rd(0, 12'h820, 32'h0101_0101, "R6 target reset");
    rd(0, 12'h81C, 32'h0, "R6 private target reads zero");
    rd(0, 12'h004, 32'h1, "R8 type word");

    // R1 set/clear
    wr(0, 12'h104, 32'h5);
    rd(0, 12'h104, 32'h5, "R1 set word");
    rd(0, 12'h184, 32'h5, "R1 clear word reads enables");
    wr(0, 12'h184, 32'h4);
    rd(0, 12'h104, 32'h1, "R1 clear one bit");
    wr(0, 12'h104, 32'h0);
    wr(0, 12'h184, 32'h0);
    rd(0, 12'h104, 32'h1, "R1 zero writes no effect");

    // R5 packing
    wr(0, 12'h420, 32'h4433_2211);
    rd(0, 12'h420, 32'h4433_2211, "R5 prio word");

    // R3 SGI config locked, R2 config readback
    wr(0, 12'hC00, 32'h0);
    rd(0, 12'hC00, 32'hAAAA_AAAA, "R3 sgi config ignored");
    wr(0, 12'hC04, 32'hFFFF_FFFF);
    rd(0, 12'hC04, 32'hAAAA_AAAA, "R2 config edge bits");
    wr(0, 12'hC04, 32'h0);
    rd(0, 12'hC04, 32'h0, "R2 config level");

    // R4 banking
    wr(0, 12'h100, 32'h3);
    rd(1, 12'h100, 32'h0, "R4 cpu1 bank untouched");
    rd(0, 12'h100, 32'h3, "R4 cpu0 bank");

    // R7 gate
    irq[16] = 1'b1;
    settle();
    expect_out(0, 0, 0, 0, "R7 forwarding off");
    wr(0, 12'h000, 32'h1);
    settle();
    expect_out(0, 1, 32, 8'h11, "R7 forwarding on");
    expect_out(1, 0, 0, 0, "R6 not routed to cpu1");

    // R6 routing
    wr(0, 12'h820, 32'h0101_0102);
    settle();
    expect_out(0, 0, 0, 0, "R6 moved off cpu0");
    expect_out(1, 1, 32, 8'h11, "R6 moved to cpu1");
    rd(0, 12'h820, 32'h0101_0102, "R6 target readback");
    wr(0, 12'h820, 32'h0101_0103);
    settle();
    expect_out(0, 1, 32, 8'h11, "R6 both cpu0");
    expect_out(1, 1, 32, 8'h11, "R6 both cpu1");

    // R10 arbitration
    wr(0, 12'h104, 32'h2);
    wr(0, 12'h420, 32'h4433_1111);
    irq[17] = 1'b1;
    settle();
    expect_out(0, 1, 32, 8'h11, "R10 tie lower id");
    wr(0, 12'h420, 32'h4433_1011);
    settle();
    expect_out(0, 1, 33, 8'h10, "R10 lower value wins");
    expect_out(1, 1, 32, 8'h11, "R10 cpu1 unrouted 33");

    // R2 level drop
    irq[16] = 1'b0; irq[17] = 1'b0;
    settle();
    expect_out(0, 0, 0, 0, "R2 level released cpu0");
    expect_out(1, 0, 0, 0, "R2 level released cpu1");

    // R2 edge latch
    wr(0, 12'hC08, 32'h0002_0000);
    wr(0, 12'h104, 32'h100);
    @(negedge clk); irq[24] = 1'b1;
    @(negedge clk); irq[24] = 1'b0;
    settle();
    expect_out(0, 1, 40, 0, "R2 edge latched");
    rd(0, 12'h204, 32'h100, "R2 pending readback");
    irq[24] = 1'b1;
    settle();
    wr(0, 12'h284, 32'h100);
    settle();
    expect_out(0, 0, 0, 0, "R2 cleared, steady high no retrigger");
    irq[24] = 1'b0;

    // R9 software interrupts
    wr(1, 12'h100, 32'h20);
    wr(0, 12'h008, 32'h0002_0005);
    settle();
    expect_out(1, 1, 5, 0, "R9 sgi5 to cpu1");
    expect_out(0, 0, 0, 0, "R9 cpu0 not named");
    rd(1, 12'h200, 32'h20, "R9 cpu1 pending");
    rd(0, 12'h200, 32'h0, "R4 cpu0 pending bank");
    wr(0, 12'h008, 32'h0001_0001);
    settle();
    expect_out(0, 1, 1, 0, "R9 sgi1 to cpu0");
    wr(1, 12'h280, 32'h20);
    settle();
    expect_out(1, 0, 0, 0, "R9 cpu1 cleared");
    expect_out(0, 1, 1, 0, "R4 cpu0 unaffected by cpu1 clear");

    // R7 gate off again
    wr(0, 12'h000, 32'h0);
    settle();
    expect_out(0, 0, 0, 0, "R7 gate off");

    wait (sb_q.size() == 0);
    #1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule